// File: doc/BRIEF.md
# Flash Program/Erase Pulse Sequencer

This block times the program and erase pulses for an on-chip flash array. Software talks to it through a byte-wide register port. It first selects one of three operations: whole-array erase, sector erase or program enable. It then arms that choice. Next it loads a 22-bit pulse length, counted in 40 ns ticks, and the block holds the matching pulse output high for exactly that long. A status byte shows whether a pulse is running and whether the last one has finished.

A second path assembles 16-bit program words from two byte writes. Each completed word goes out with a one-cycle strobe together with its target word address. The address register then steps by one, so a run of words lands in consecutive locations without software rewriting the address. The flash array itself and its high-voltage circuitry are outside the block.

With a 50 MHz clock and the default tick divider of 2, one count equals 40 ns. The divider is a parameter, so other clock rates keep the same tick by scaling it.

Top module: `flash_pulse_ctrl`

## Requirements
- R1: After reset, every register reads zero, no pulse output is high, and the word strobe is low.
- R2: Writing register 0 with bit 7 clear and exactly one of bits 0 (array erase), 1 (sector erase), 2 (program enable) set stores that selection and disarms. Writing bit 7 clear with any other bit 0..2 pattern clears the selection. Writing bit 7 set arms the block only when a selection is stored and bits 0..2 equal it; otherwise the write has no effect. Register 0 reads back as {armed, 4'b0, selection[2:0]}.
- R3: The pulse-length registers are ignored unless the block is armed and idle. The pulse length is split across register 1 (length bits 21:16, taken from data bits 5:0), register 2 (bits 15:8) and register 3 (bits 7:0). Writing register 3 commits the full length, starts the pulse and disarms.
- R4: Arming preloads the high and middle length bytes from the selected operation's default: 0x3FFFFF for array erase, 0x0FFFFF for sector erase, 0x000190 for program enable. These bytes read back through registers 1 and 2.
- R5: A committed length N > 0 keeps the busy bit (register 8, bit 0) set for exactly N × TICK_DIV clock cycles.
- R6: While busy, only the output of the selected operation is high. While idle, all three pulse outputs are low.
- R7: The done bit (register 8, bit 1) sets in the cycle in which busy clears, and clears on the next successful arm.
- R8: Writes to register 0 while busy have no effect on the selection, the arm state or the running pulse.
- R9: Writing register 4 stores a high data byte. Writing register 5 then emits a one-cycle word strobe carrying {high, low} and the current word address. A register 5 write with no pending high byte is ignored.
- R10: Each emitted word advances the word address register by one, wrapping at 2^ADDR_W. Register 6 holds the upper address bits and register 7 the lower eight; both are writable and readable.
- R11: Committing a length of zero produces no pulse and sets done at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for writes and reads |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data of the register at reg_addr (combinational) |
| flash_chip_erase | output | 1 | Whole-array erase pulse |
| flash_sector_erase | output | 1 | Sector erase pulse |
| flash_prog_enable | output | 1 | Program enable pulse |
| flash_addr | output | ADDR_W | Word address that goes with the strobe |
| flash_wdata | output | 16 | Assembled program word |
| flash_wstrobe | output | 1 | One-cycle word-valid strobe |

## Verification
Every register write takes effect at the clock edge that samples it. Read data is combinational, so a read is due a fraction of a cycle after the index is set. The pulse outputs rise at the edge that commits the low length byte and stay high for N × TICK_DIV edges. The bench counts the falling edges at which each pulse output is high, and compares those counts with that product, which gives exact cycle accuracy without depending on where the pulse starts. The word strobe is registered by the same edge that takes the low data byte, so the bench samples it half a cycle later. It also keeps a falling-edge strobe counter, which proves that an ignored write produced no strobe.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;

    localparam int REG_AW   = 4;
    localparam int DEF_W    = 22;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 4'd0,
        RA_LEN_HI  = 4'd1,
        RA_LEN_MID = 4'd2,
        RA_LEN_LO  = 4'd3,
        RA_DAT_HI  = 4'd4,
        RA_DAT_LO  = 4'd5,
        RA_ADR_HI  = 4'd6,
        RA_ADR_LO  = 4'd7,
        RA_STATUS  = 4'd8
    } reg_idx_e;

    // bit positions of the operation select field
    localparam int OPB_ARRAY  = 0;
    localparam int OPB_SECTOR = 1;
    localparam int OPB_PROG   = 2;
    localparam int ARM_BIT    = 7;

    localparam logic [DEF_W-1:0] LEN_DEF_ARRAY  = 22'h3FFFFF;
    localparam logic [DEF_W-1:0] LEN_DEF_SECTOR = 22'h0FFFFF;
    localparam logic [DEF_W-1:0] LEN_DEF_PROG   = 22'h000190;

    typedef struct packed {
        logic       armed;
        logic [2:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic        valid;
        logic [15:0] word;
    } wword_t;

    function automatic logic sel_is_single(input logic [2:0] v);
        return (v == 3'b001) || (v == 3'b010) || (v == 3'b100);
    endfunction

    function automatic logic [DEF_W-1:0] default_len(input logic [2:0] sel);
        logic [DEF_W-1:0] r;
        r = '0;
        if (sel[OPB_ARRAY])  r = LEN_DEF_ARRAY;
        if (sel[OPB_SECTOR]) r = LEN_DEF_SECTOR;
        if (sel[OPB_PROG])   r = LEN_DEF_PROG;
        return r;
    endfunction

endpackage

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_pulse_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [REG_AW-1:0]         idx,
    input  logic [7:0]                wdata,
    input  logic                      busy,
    output ctrl_t                     ctrl_q,
    output logic [LEN_W-1:0]          stage_q,
    output logic                      arm_evt,
    output logic                      commit,
    output logic [LEN_W-1:0]          commit_len
);
    localparam int HI_W = LEN_W - 16;

    logic wr_ctrl;
    logic len_ok;
    logic arm_ok;

    assign wr_ctrl   = wr && (idx == RA_CTRL) && !busy;
    assign len_ok    = wr && ctrl_q.armed && !busy;
    assign arm_ok    = wr_ctrl && wdata[ARM_BIT] && !ctrl_q.armed &&
                       (ctrl_q.sel != 3'b000) && (wdata[2:0] == ctrl_q.sel);
    assign arm_evt   = arm_ok;
    assign commit    = len_ok && (idx == RA_LEN_LO);
    assign commit_len = {stage_q[LEN_W-1:8], wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stage_q <= '0;
        end else if (commit) begin
            ctrl_q.armed <= 1'b0;
        end else if (arm_ok) begin
            ctrl_q.armed <= 1'b1;
            stage_q      <= LEN_W'(default_len(ctrl_q.sel));
        end else if (wr_ctrl && !wdata[ARM_BIT]) begin
            if (sel_is_single(wdata[2:0])) begin
                ctrl_q.sel   <= wdata[2:0];
                ctrl_q.armed <= 1'b0;
            end else begin
                ctrl_q <= '0;
            end
        end else if (len_ok && idx == RA_LEN_HI) begin
            stage_q[LEN_W-1:16] <= wdata[HI_W-1:0];
        end else if (len_ok && idx == RA_LEN_MID) begin
            stage_q[15:8] <= wdata;
        end
    end

endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
    parameter int LEN_W    = 22,
    parameter int TICK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [2:0]       load_op,
    input  logic             arm_evt,
    output logic             busy,
    output logic             done,
    output logic [2:0]       op_pulse
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [LEN_W-1:0] cnt_q;
    logic [2:0]       op_q;
    logic             tick;

    assign busy = (cnt_q != '0);

    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;
            assign tick = (div_q == DIV_W'(TICK_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || load || !busy || tick) div_q <= '0;
                else                              div_q <= div_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            op_q  <= '0;
            done  <= 1'b0;
        end else if (load) begin
            cnt_q <= load_len;
            op_q  <= load_op;
            done  <= (load_len == '0);
        end else begin
            if (busy && tick) cnt_q <= cnt_q - 1'b1;
            if (arm_evt)                                done <= 1'b0;
            else if (busy && tick && cnt_q == LEN_W'(1)) done <= 1'b1;
        end
    end

    assign op_pulse = busy ? op_q : 3'b000;

endmodule

// File: rtl/flash_data_path.sv
module flash_data_path
    import flash_pulse_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] out_addr,
    output logic [15:0]       out_word,
    output logic              out_strobe
);
    localparam int AHI_W = ADDR_W - 8;

    logic [7:0] hi_q;
    logic       hi_pending;
    wword_t     nxt;

    assign nxt.valid = wr && (idx == RA_DAT_LO) && hi_pending;
    assign nxt.word  = {hi_q, wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            hi_pending <= 1'b0;
            addr_q     <= '0;
            out_addr   <= '0;
            out_word   <= '0;
            out_strobe <= 1'b0;
        end else begin
            out_strobe <= nxt.valid;
            if (nxt.valid) begin
                out_word   <= nxt.word;
                out_addr   <= addr_q;
                addr_q     <= addr_q + 1'b1;
                hi_pending <= 1'b0;
            end else if (wr && idx == RA_DAT_HI) begin
                hi_q       <= wdata;
                hi_pending <= 1'b1;
            end else if (wr && idx == RA_ADR_HI) begin
                addr_q[ADDR_W-1:8] <= wdata[AHI_W-1:0];
            end else if (wr && idx == RA_ADR_LO) begin
                addr_q[7:0] <= wdata;
            end
        end
    end

endmodule

// File: rtl/flash_pulse_ctrl.sv
module flash_pulse_ctrl
    import flash_pulse_pkg::*;
#(
    parameter int LEN_W    = 22,
    parameter int TICK_DIV = 2,
    parameter int ADDR_W   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              flash_chip_erase,
    output logic              flash_sector_erase,
    output logic              flash_prog_enable,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [15:0]       flash_wdata,
    output logic              flash_wstrobe
);
    ctrl_t             ctrl_q;
    logic [LEN_W-1:0]  stage_q;
    logic              arm_evt;
    logic              commit;
    logic [LEN_W-1:0]  commit_len;
    logic              busy;
    logic              done;
    logic [2:0]        op_pulse;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        sel_now;

    assign sel_now = ctrl_q.sel;

    flash_ctl_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_addr), .wdata(reg_wdata),
        .busy(busy), .ctrl_q(ctrl_q), .stage_q(stage_q), .arm_evt(arm_evt),
        .commit(commit), .commit_len(commit_len)
    );

    flash_pulse_timer #(.LEN_W(LEN_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk(clk), .rst(rst), .load(commit), .load_len(commit_len),
        .load_op(ctrl_q.sel), .arm_evt(arm_evt), .busy(busy), .done(done),
        .op_pulse(op_pulse)
    );

    flash_data_path #(.ADDR_W(ADDR_W)) u_data (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_addr), .wdata(reg_wdata),
        .addr_q(addr_q), .out_addr(flash_addr), .out_word(flash_wdata),
        .out_strobe(flash_wstrobe)
    );

    assign flash_chip_erase   = op_pulse[OPB_ARRAY];
    assign flash_sector_erase = op_pulse[OPB_SECTOR];
    assign flash_prog_enable  = op_pulse[OPB_PROG];

    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rdata = {ctrl_q.armed, 4'b0000, ctrl_q.sel};
            RA_LEN_HI:  reg_rdata = 8'(stage_q >> 16);
            RA_LEN_MID: reg_rdata = stage_q[15:8];
            RA_ADR_HI:  reg_rdata = 8'(addr_q >> 8);
            RA_ADR_LO:  reg_rdata = addr_q[7:0];
            RA_STATUS:  reg_rdata = {6'b000000, done, busy};
            default:    reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_pulse_chk.sv
module flash_pulse_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              ce,
    input logic              se,
    input logic              pe,
    input logic [2:0]        sel,
    input logic              wstrobe,
    input logic [ADDR_W-1:0] waddr,
    input logic [ADDR_W-1:0] addr_q
);
    AST_ONE_OP_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        $countones({ce, se, pe}) <= 1); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(ce || se || pe)); // R6
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sel)); // R8
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wstrobe |=> !wstrobe); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        wstrobe |-> (addr_q == ADDR_W'(waddr + 1'b1))); // R10
endmodule

bind flash_pulse_ctrl flash_pulse_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .ce(flash_chip_erase), .se(flash_sector_erase), .pe(flash_prog_enable),
    .sel(sel_now), .wstrobe(flash_wstrobe), .waddr(flash_addr), .addr_q(addr_q)
);

// File: tb/sim_flash_pulse_ctrl.sv
module sim_flash_pulse_ctrl;
    localparam int TDIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ce, se, pe;
    logic [14:0] faddr;
    logic [15:0] fdata;
    logic        fstb;

    int checks = 0;
    int errors = 0;
    int ce_cnt = 0, se_cnt = 0, pe_cnt = 0, stb_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_pulse_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flash_chip_erase(ce), .flash_sector_erase(se), .flash_prog_enable(pe),
        .flash_addr(faddr), .flash_wdata(fdata), .flash_wstrobe(fstb)
    );

    always @(negedge clk) begin
        ce_cnt  <= ce_cnt + int'(ce);
        se_cnt  <= se_cnt + int'(se);
        pe_cnt  <= pe_cnt + int'(pe);
        stb_cnt <= stb_cnt + int'(fstb);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_counts();
        ce_cnt = 0; se_cnt = 0; pe_cnt = 0; stb_cnt = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!(ce || se || pe)) break;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'd8, d); check("R1 status", d, 0);
        rd(4'd0, d); check("R1 ctrl", d, 0);
        rd(4'd7, d); check("R1 addr", d, 0);
        check("R1 outputs", {ce, se, pe, fstb}, 0);
    endtask

    task automatic t_arm_rules();
        logic [7:0] d;
        wr(4'd0, 8'h81); rd(4'd0, d); check("R2 arm without select", d, 8'h00);
        wr(4'd0, 8'h02); wr(4'd0, 8'h81); rd(4'd0, d); check("R2 arm mismatch", d, 8'h02);
        wr(4'd0, 8'h03); rd(4'd0, d); check("R2 multi select clears", d, 8'h00);
        clear_counts();
        wr(4'd3, 8'h05); repeat (4) @(negedge clk); #1;
        check("R3 length ignored unarmed", ce_cnt + se_cnt + pe_cnt, 0);
        rd(4'd8, d); check("R3 status unarmed", d, 0);
    endtask

    task automatic t_sector();
        logic [7:0] d;
        wr(4'd0, 8'h02); wr(4'd0, 8'h82);
        rd(4'd0, d); check("R2 armed readback", d, 8'h82);
        rd(4'd2, d); check("R4 sector default mid", d, 8'hFF);
        rd(4'd1, d); check("R4 sector default hi", d, 8'h0F);
        wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        clear_counts();
        wr(4'd3, 8'h05);
        rd(4'd8, d); check("R5 busy while running", d & 8'h01, 1);
        wait_idle();
        check("R5 sector length", se_cnt, 5 * TDIV);
        check("R6 other outputs idle", ce_cnt + pe_cnt, 0);
        rd(4'd8, d); check("R7 done after pulse", d, 8'h02);
        rd(4'd0, d); check("R3 disarmed after commit", d, 8'h02);
    endtask

    task automatic t_array_hold();
        logic [7:0] d;
        wr(4'd0, 8'h01); wr(4'd0, 8'h81);
        rd(4'd8, d); check("R7 done cleared by arm", d, 0);
        rd(4'd1, d); check("R4 array default hi", d, 8'h3F);
        wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        clear_counts();
        wr(4'd3, 8'd20);
        wr(4'd0, 8'h04);
        wr(4'd0, 8'h84);
        rd(4'd0, d); check("R8 ctrl held while busy", d, 8'h01);
        wait_idle();
        check("R8 pulse unaffected", ce_cnt, 20 * TDIV);
        check("R6 array only", se_cnt + pe_cnt, 0);
    endtask

    task automatic t_prog_default();
        logic [7:0] d;
        wr(4'd0, 8'h04); wr(4'd0, 8'h84);
        rd(4'd2, d); check("R4 prog default mid", d, 8'h01);
        rd(4'd1, d); check("R4 prog default hi", d, 8'h00);
        clear_counts();
        wr(4'd3, 8'h90);
        wait_idle();
        check("R4 prog default length", pe_cnt, 'h190 * TDIV);
        check("R6 prog only", ce_cnt + se_cnt, 0);
    endtask

    task automatic t_zero();
        logic [7:0] d;
        wr(4'd0, 8'h02); wr(4'd0, 8'h82);
        wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        clear_counts();
        wr(4'd3, 8'h00);
        repeat (3) @(negedge clk); #1;
        check("R11 no pulse", ce_cnt + se_cnt + pe_cnt, 0);
        rd(4'd8, d); check("R11 done at once", d, 8'h02);
    endtask

    task automatic t_data();
        logic [7:0] d;
        wr(4'd6, 8'h01); wr(4'd7, 8'h20);
        wr(4'd4, 8'hAB);
        clear_counts();
        wr(4'd5, 8'hCD);
        check("R9 strobe", fstb, 1);
        check("R9 word", fdata, 16'hABCD);
        check("R9 address", faddr, 15'h0120);
        rd(4'd7, d); check("R10 increment lo", d, 8'h21);
        rd(4'd6, d); check("R10 increment hi", d, 8'h01);
        check("R9 single strobe", stb_cnt, 1);
        clear_counts();
        wr(4'd5, 8'h11);
        repeat (2) @(negedge clk); #1;
        check("R9 lone low ignored", stb_cnt, 0);
        rd(4'd7, d); check("R9 address unchanged", d, 8'h21);
        wr(4'd6, 8'h7F); wr(4'd7, 8'hFF);
        wr(4'd4, 8'h01); wr(4'd5, 8'h02);
        check("R10 last address", faddr, 15'h7FFF);
        rd(4'd7, d); check("R10 wrap lo", d, 0);
        rd(4'd6, d); check("R10 wrap hi", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_arm_rules();
        t_sector();
        t_array_hold();
        t_prog_default();
        t_zero();
        t_data();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule